// File: doc/BRIEF.md
# Local interrupt controller timer

This block is the countdown timer of a per-processor interrupt controller. Software programs it through a small word-wide register port. The port holds four registers: a timer entry with a vector, a mask bit and a periodic-mode bit; an initial count; a divide setting; and a read-only live count. A power-of-two prescaler divides the clock into ticks. The 32-bit counter steps down once per tick.

When the count expires, the block emits a one-cycle request that carries the programmed 8-bit vector. In one-shot mode the counter then rests at zero. In periodic mode it reloads and keeps running.

Loading the initial count restarts both the counter and the prescaler phase. The time from a load to the first expiry is therefore exact: (initial count + 1) divided ticks.

Top module: `lic_timer`

## Requirements
- R1: After reset the entry reads 0x0001_0000, and the divide, initial-count and current-count registers read 0. No request is raised.
- R2: Register word index 3 is the divide setting and keeps only bits 0, 1 and 3 (mask 0xB). The 3-bit code is {bit3, bit1, bit0}, and the divisor is 2^((code+1) mod 8). So 0xB divides by 1, 0x0 by 2, 0x3 by 16, 0x8 by 32 and 0xA by 128.
- R3: Register word index 0 is the timer entry. Bits [7:0] hold the vector, bit 16 is the mask and bit 17 selects periodic mode; all other bits read 0.
- R4: A write to register word index 1 (initial count) loads the counter at once and restarts the prescaler phase. The current count reads the new value in the next cycle, and the first expiry comes (N+1)*D clock cycles after the write edge.
- R5: In one-shot mode the count falls by one each tick and stops at 0, and exactly one expiry occurs, at (N+1)*D cycles.
- R6: In periodic mode expiries recur every (N+1)*D cycles, and the count reads N again right after each expiry.
- R7: An initial count of 0 produces no expiry, in either mode.
- R8: While the mask bit is set, no request is raised, but counting continues down to 0.
- R9: The request output `tmr_fire` is high for exactly one cycle per expiry, with `tmr_vec` equal to the entry vector.
- R10: Register word index 2 reads the live count. Reads have no side effect, and writes to this index are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_addr | input | 2 | Register word index (0 entry, 1 initial, 2 current, 3 divide) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tmr_fire | output | 1 | Single-cycle expiry request |
| tmr_vec | output | 8 | Vector accompanying `tmr_fire` |

## Verification
The assertions assume that `reg_addr` and `reg_wr` are known on every clock edge, and that at most one register is written per cycle. The step and hold properties rely on the counter changing only on a load or a tick.

The bench drives every input on the falling edge, one write at a time, and holds the address on the current-count index between writes. Each write therefore lands on exactly one rising edge, and the prescaler divide is always set before the load that a scenario times.

// File: rtl/lic_tmr_pkg.sv
package lic_tmr_pkg;
  localparam int REG_W = 32;
  localparam int SH_W  = 3;

  localparam logic [1:0] A_ENTRY = 2'd0;
  localparam logic [1:0] A_INIT  = 2'd1;
  localparam logic [1:0] A_CURR  = 2'd2;
  localparam logic [1:0] A_DIV   = 2'd3;

  localparam int ENT_MASK_BIT = 16;
  localparam int ENT_PER_BIT  = 17;
  localparam logic [3:0] DIV_KEEP = 4'hB;

  // prescaler shift: code {b3,b1,b0}, plus one, wrapping at eight
  function automatic logic [SH_W-1:0] div_shift(input logic [3:0] cfg);
    logic [SH_W-1:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + 3'd1;
  endfunction

  // low-bit mask of the free-running phase counter for a given shift
  function automatic logic [(1<<SH_W)-2:0] phase_mask(input logic [SH_W-1:0] sh);
    logic [(1<<SH_W)-2:0] one;
    one = '0;
    one[0] = 1'b1;
    return (one << sh) - one;
  endfunction
endpackage

// File: rtl/lic_tmr_regs.sv
module lic_tmr_regs
  import lic_tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [1:0]            addr_i,
  input  logic [REG_W-1:0]      wdata_i,
  input  logic [CNT_W-1:0]      cnt_i,
  output logic [REG_W-1:0]      rdata_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic                  mask_o,
  output logic                  periodic_o,
  output logic [SH_W-1:0]       shift_o,
  output logic [CNT_W-1:0]      init_o,
  output logic                  load_o
);
  logic [VEC_W-1:0] vec_q;
  logic             mask_q, per_q;
  logic [3:0]       div_q;
  logic [CNT_W-1:0] init_q;

  assign load_o = wr_i && (addr_i == A_INIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q  <= '0;
      mask_q <= 1'b1;
      per_q  <= 1'b0;
      div_q  <= '0;
      init_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_ENTRY: begin
          vec_q  <= wdata_i[VEC_W-1:0];
          mask_q <= wdata_i[ENT_MASK_BIT];
          per_q  <= wdata_i[ENT_PER_BIT];
        end
        A_INIT:  init_q <= wdata_i[CNT_W-1:0];
        A_DIV:   div_q  <= wdata_i[3:0] & DIV_KEEP;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_ENTRY: begin
        rdata_o[VEC_W-1:0]   = vec_q;
        rdata_o[ENT_MASK_BIT] = mask_q;
        rdata_o[ENT_PER_BIT]  = per_q;
      end
      A_INIT:  rdata_o = REG_W'(init_q);
      A_CURR:  rdata_o = REG_W'(cnt_i);
      default: rdata_o = REG_W'(div_q);
    endcase
  end

  assign vec_o      = vec_q;
  assign mask_o     = mask_q;
  assign periodic_o = per_q;
  assign shift_o    = div_shift(div_q);
  assign init_o     = init_q;

  // R2: divide register never holds bit 2
  assert_div_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && addr_i == A_DIV |=> div_q[2] == 1'b0);
endmodule

// File: rtl/lic_tmr_prescaler.sv
module lic_tmr_prescaler
  import lic_tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart_i,
  input  logic [SH_W-1:0] shift_i,
  output logic            tick_o
);
  localparam int PRE_W = (1 << SH_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] msk;

  assign msk    = phase_mask(shift_i);
  assign tick_o = (pre_q & msk) == msk;

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i) pre_q <= '0;
    else                     pre_q <= pre_q + PRE_W'(1);
  end

  // R2: with a divisor above one, a tick is never followed by another
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o && shift_i != '0 && !restart_i |=> !tick_o || shift_i == '0);
endmodule

// File: rtl/lic_tmr_counter.sv
module lic_tmr_counter #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic             mask_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o,
  output logic [VEC_W-1:0] fire_vec_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q, fire_q;
  logic [VEC_W-1:0] fvec_q;
  logic             at_zero, expire_w, reload_w;

  assign at_zero  = (cnt_q == '0);
  assign reload_w = periodic_i && (init_i != '0);
  assign expire_w = tick_i && !load_i && at_zero && (periodic_i ? reload_w : armed_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
      fvec_q  <= '0;
    end else begin
      if (load_i) begin
        cnt_q   <= load_val_i;
        armed_q <= (load_val_i != '0);
      end else if (tick_i) begin
        if (!at_zero)      cnt_q <= cnt_q - CNT_W'(1);
        else if (reload_w) cnt_q <= init_i;
        if (expire_w && !periodic_i) armed_q <= 1'b0;
      end
      fire_q <= expire_w && !mask_i;
      fvec_q <= vec_i;
    end
  end

  assign cnt_o      = cnt_q;
  assign fire_o     = fire_q;
  assign fire_vec_o = fvec_q;

  assert_fire_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |=> !fire_q);
  assert_fire_unmasked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> !$past(mask_i));
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !load_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  assert_oneshot_rest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !periodic_i && !load_i && cnt_q == '0 |=> cnt_q == '0);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !load_i |=> $stable(cnt_q));
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));
  assert_zero_periodic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_i && init_i == '0 && cnt_q == '0 && !load_i |=> !fire_q);
endmodule

// File: rtl/lic_timer.sv
module lic_timer
  import lic_tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             tmr_fire,
  output logic [VEC_W-1:0] tmr_vec
);
  logic [CNT_W-1:0] cnt, init;
  logic [VEC_W-1:0] vec;
  logic             mask, periodic, load, tick;
  logic [SH_W-1:0]  shift;

  lic_tmr_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .cnt_i(cnt), .rdata_o(reg_rdata),
    .vec_o(vec), .mask_o(mask), .periodic_o(periodic),
    .shift_o(shift), .init_o(init), .load_o(load)
  );

  lic_tmr_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .restart_i(load), .shift_i(shift), .tick_o(tick)
  );

  lic_tmr_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(reg_wdata[CNT_W-1:0]),
    .init_i(init), .tick_i(tick), .periodic_i(periodic), .mask_i(mask),
    .vec_i(vec), .cnt_o(cnt), .fire_o(tmr_fire), .fire_vec_o(tmr_vec)
  );
endmodule

// File: tb/tb_lic_timer.sv
`timescale 1ns/1ps
module tb_lic_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd2;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tmr_fire;
  logic [7:0]  tmr_vec;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  lic_timer dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int divisor(input logic [3:0] cfg);
    int code;
    code = (cfg[3] ? 4 : 0) + (cfg[1] ? 2 : 0) + (cfg[0] ? 1 : 0);
    return 2 ** ((code + 1) % 8);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata; reg_addr = 2'd2;
  endtask

  task automatic watch(input int ncyc, input int probe_k, output int first, output int second,
                       output int nf, output logic [31:0] probe_val, output int bad_w,
                       output logic [7:0] vseen);
    bit prev = 0;
    first = -1; second = -1; nf = 0; probe_val = '1; bad_w = 0; vseen = '0;
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      if (tmr_fire) begin
        nf++;
        vseen = tmr_vec;
        if (first < 0) first = k; else if (second < 0) second = k;
        if (prev) bad_w++;
      end
      prev = tmr_fire;
      if (k == probe_k) probe_val = reg_rdata;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk(v == 32'h0001_0000, "R1 entry reset", v, 32'h0001_0000);
    rd(2'd3, v); chk(v == 0, "R1 divide reset", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 initial reset", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 current reset", v, 0);
    chk(tmr_fire == 1'b0, "R1 no request", 32'(tmr_fire), 0);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr(2'd3, 32'hFFFF_FFFF); rd(2'd3, v); chk(v == 32'hB, "R2 divide mask", v, 32'hB);
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v);
    chk(v == 32'h0003_00FF, "R3 entry fields", v, 32'h0003_00FF);
    wr(2'd0, 32'h0001_0000);
  endtask

  task automatic t_oneshot(input logic [3:0] cfg, input int n, input logic [7:0] vec);
    int d, f1, f2, nf, bw; logic [31:0] pv, v; logic [7:0] vs;
    d = divisor(cfg);
    wr(2'd3, 32'(cfg)); wr(2'd0, 32'(vec));
    wr(2'd1, 32'(n));
    rd(2'd2, v); chk(v == 32'(n), "R4 count after load", v, 32'(n));
    watch((n + 1) * d + 3 * d + 4, d, f1, f2, nf, pv, bw, vs);
    chk(f1 == (n + 1) * d, "R5 one-shot expiry cycle", 32'(f1), 32'((n + 1) * d));
    chk(nf == 1, "R5 single expiry", 32'(nf), 1);
    chk(pv == 32'(n - 1), "R2 count after one divided tick", pv, 32'(n - 1));
    chk(bw == 0 && vs == vec, "R9 pulse width and vector", 32'(vs), 32'(vec));
    rd(2'd2, v); chk(v == 0, "R5 count rests at zero", v, 0);
  endtask

  task automatic t_periodic(input logic [3:0] cfg, input int n);
    int d, p, f1, f2, nf, bw; logic [31:0] pv; logic [7:0] vs;
    d = divisor(cfg); p = (n + 1) * d;
    wr(2'd3, 32'(cfg)); wr(2'd0, 32'h0002_0033);
    wr(2'd1, 32'(n));
    watch(3 * p + 1, p, f1, f2, nf, pv, bw, vs);
    chk(f1 == p && f2 == 2 * p, "R6 periodic spacing", 32'(f2), 32'(2 * p));
    chk(nf == 3, "R6 periodic expiry count", 32'(nf), 3);
    chk(pv == 32'(n), "R6 count wraps to initial", pv, 32'(n));
    chk(bw == 0 && vs == 8'h33, "R9 periodic pulse", 32'(vs), 32'h33);
  endtask

  task automatic t_zero();
    int f1, f2, nf, bw; logic [31:0] pv; logic [7:0] vs;
    wr(2'd3, 32'hB); wr(2'd0, 32'h0002_0010); wr(2'd1, 0);
    watch(200, 1, f1, f2, nf, pv, bw, vs);
    chk(nf == 0, "R7 periodic zero never fires", 32'(nf), 0);
    wr(2'd0, 32'h0000_0010); wr(2'd1, 0);
    watch(50, 1, f1, f2, nf, pv, bw, vs);
    chk(nf == 0, "R7 one-shot zero never fires", 32'(nf), 0);
  endtask

  task automatic t_mask();
    int f1, f2, nf, bw; logic [31:0] pv; logic [7:0] vs;
    wr(2'd3, 32'hB); wr(2'd0, 32'h0001_0055); wr(2'd1, 4);
    watch(40, 20, f1, f2, nf, pv, bw, vs);
    chk(nf == 0, "R8 masked no request", 32'(nf), 0);
    chk(pv == 0, "R8 masked count still runs", pv, 0);
  endtask

  task automatic t_restart();
    int f1, f2, nf, bw; logic [31:0] pv; logic [7:0] vs;
    wr(2'd3, 32'hB); wr(2'd0, 32'h0000_0066); wr(2'd1, 20);
    watch(5, 1, f1, f2, nf, pv, bw, vs);
    wr(2'd1, 3);
    watch(30, 1, f1, f2, nf, pv, bw, vs);
    chk(f1 == 4 && nf == 1, "R4 reload restarts count", 32'(f1), 4);
  endtask

  task automatic t_curr_write();
    logic [31:0] v;
    int f1, f2, nf, bw; logic [31:0] pv; logic [7:0] vs;
    wr(2'd3, 32'hB); wr(2'd0, 32'h0001_0000); wr(2'd1, 50);
    watch(3, 1, f1, f2, nf, pv, bw, vs);
    rd(2'd2, v); chk(v == 47, "R10 live count read", v, 47);
    rd(2'd2, v); chk(v == 47, "R10 read has no side effect", v, 47);
    wr(2'd2, 32'd7);
    rd(2'd2, v); chk(v == 46, "R10 write to current ignored", v, 46);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_oneshot(4'hB, 5, 8'h41);
    t_oneshot(4'h0, 3, 8'h7E);
    t_oneshot(4'h3, 2, 8'h90);
    t_oneshot(4'hA, 1, 8'hC3);
    t_periodic(4'h8, 2);
    t_periodic(4'hB, 1);
    t_zero();
    t_mask();
    t_restart();
    t_curr_write();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule